// File: doc/BRIEF.md
# Predicated Lane Array with Broadcast Sequencer

This block is a small array of processing lanes run by one sequencer. The sequencer owns the only program counter and an instruction store. Each cycle it reads one instruction word, decodes it once, and hands the same operation to every lane in that cycle. A lane has its own register bank, its own index register and a private data store. The index register is the only address a lane uses for loads and stores. Lanes therefore work on different data, and can work at different addresses, while all of them follow one instruction stream.

Each lane carries an enable predicate. A lane whose predicate is clear skips ordinary operations and keeps its state. The two predicate instructions reach every lane whatever its predicate, so a disabled lane can be turned on again. The only change of control flow is a jump of the shared program counter, so all lanes take it together.

A host loads programs and reads or writes any lane's data store through one port. That port works only while the sequencer is halted. After reset the sequencer is halted, so the host can load a program and data before it pulses `start`.

Top module: `simt_array`

## Requirements
- R1: After reset the program counter is 0, the sequencer is halted, all four lanes are enabled, and every lane register and index register reads as zero.
- R2: While running, exactly one instruction executes per clock. Every non-branch, non-halt instruction advances the program counter by one. A `start` pulse sets the counter to 0 and starts execution on the next edge.
- R3: Instruction word bits [15:12] are the opcode, [11:8] the destination register `rd` (16 registers per lane) and [7:0] the immediate; opcode 1 writes the immediate to `rd`, opcode 2 sets `rd = rd + r[imm[3:0]]` and opcode 3 sets `rd = rd - r[imm[3:0]]`, all modulo 256.
- R4: Opcode 4 loads `rd` from the lane's own store at its index register, and opcode 5 stores `rd` there, so lanes with different index values touch different addresses on the same instruction.
- R5: Opcode 6 adds `imm[3:0]` to the index register modulo 16.
- R6: A lane with its predicate clear leaves its registers, index register and store unchanged for opcodes 1 to 6.
- R7: Opcode 7 sets every lane's predicate to (`rd` == 0) and opcode 8 enables every lane. Both act on disabled lanes as well. No other instruction changes any predicate.
- R8: Opcode 9 loads the program counter with `imm[5:0]` for all lanes at once. Opcode 0 halts and leaves the program counter on the halt instruction.
- R9: While halted, a host write to the lane selected by `host_lane` at `host_addr` completes in one cycle, and a host read shows its data on `host_rdata` one cycle after the request. While running, host requests are ignored and `host_rdata` holds.
- R10: A store by one lane changes only that lane's store. Addresses the program does not target keep their contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (used while halted) |
| prog_we | input | 1 | Instruction store write enable (halted only) |
| prog_addr | input | 6 | Instruction store write address |
| prog_data | input | 16 | Instruction word to write |
| host_en | input | 1 | Host data access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_lane | input | 2 | Lane whose store is accessed |
| host_addr | input | 4 | Word address in that lane's store |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| halted | output | 1 | Sequencer is halted |
| pc | output | 6 | Program counter |
| active | output | 4 | Per-lane enable predicates |

## Verification
Every lane store is preloaded with a different arithmetic pattern, so the lanes hold different operands. A cross-lane mixup or a wrong address then shows up as a wrong value. The arithmetic program is repeated with immediates 0, 1, 0x7F, 0x80 and 0xFF, which separates correct modulo-256 wrap from sign or carry errors. Predicate programs disable all but one lane, move only that lane's index, and then store, which separates skipped lanes from executing ones and shows whether the predicate instructions reach disabled lanes. Jump, halt, index wrap and host access during a run each have their own short program, and the cycle count of a run is compared with the number of instructions executed.

// File: rtl/simt_pkg.sv
package simt_pkg;

    localparam int INSTR_W = 16;
    localparam int OPC_W   = 4;
    localparam int SEL_W   = 4;
    localparam int IMM_W   = 8;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT   = 4'd0,
        OP_LDI    = 4'd1,
        OP_ADD    = 4'd2,
        OP_SUB    = 4'd3,
        OP_LD     = 4'd4,
        OP_ST     = 4'd5,
        OP_IXADD  = 4'd6,
        OP_SETACT = 4'd7,
        OP_ALLACT = 4'd8,
        OP_JMP    = 4'd9
    } op_e;

endpackage

// File: rtl/simt_ctrl.sv
module simt_ctrl
    import simt_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               prog_we_i,
    input  logic [PC_W-1:0]    prog_addr_i,
    input  logic [INSTR_W-1:0] prog_data_i,
    output logic [PC_W-1:0]    pc_o,
    output logic               halted_o,
    output logic               exec_o,
    output op_e                op_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic [IMM_W-1:0]   imm_o
);

    typedef struct packed {
        logic                                 running;
        logic [PC_W-1:0]                      pc;
        logic [IMEM_DEPTH-1:0][INSTR_W-1:0]   imem;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic [INSTR_W-1:0] instr;

    assign instr    = st_q.imem[st_q.pc];
    assign op_o     = op_e'(instr[INSTR_W-1 -: OPC_W]);
    assign sel_o    = instr[IMM_W +: SEL_W];
    assign imm_o    = instr[IMM_W-1:0];
    assign pc_o     = st_q.pc;
    assign halted_o = ~st_q.running;
    assign exec_o   = st_q.running;

    always_comb begin
        st_d = st_q;
        if (st_q.running) begin
            case (op_o)
                OP_HALT: st_d.running = 1'b0;
                OP_JMP:  st_d.pc      = imm_o[PC_W-1:0];
                default: st_d.pc      = st_q.pc + 1'b1;
            endcase
        end else begin
            if (prog_we_i) begin
                st_d.imem[prog_addr_i] = prog_data_i;
            end
            if (start_i) begin
                st_d.pc      = '0;
                st_d.running = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/simt_lane.sv
module simt_lane
    import simt_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MEM_DEPTH = 16,
    parameter int NREGS     = 16,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int RW       = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec_i,
    input  op_e               op_i,
    input  logic [RW-1:0]     sel_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              host_we_i,
    input  logic [AW-1:0]     host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic              active_o,
    output logic [DATA_W-1:0] host_rdata_o
);

    typedef struct packed {
        logic                               active;
        logic [AW-1:0]                      ix;
        logic [NREGS-1:0][DATA_W-1:0]       regs;
        logic [MEM_DEPTH-1:0][DATA_W-1:0]   mem;
    } lane_t;

    lane_t st_d, st_q;
    logic [RW-1:0] src;

    assign src          = imm_i[RW-1:0];
    assign active_o     = st_q.active;
    assign host_rdata_o = st_q.mem[host_addr_i];

    always_comb begin
        st_d = st_q;
        if (exec_i) begin
            case (op_i)
                OP_SETACT: st_d.active = (st_q.regs[sel_i] == '0);
                OP_ALLACT: st_d.active = 1'b1;
                default: begin
                    if (st_q.active) begin
                        case (op_i)
                            OP_LDI:   st_d.regs[sel_i] = DATA_W'(imm_i);
                            OP_ADD:   st_d.regs[sel_i] = st_q.regs[sel_i] + st_q.regs[src];
                            OP_SUB:   st_d.regs[sel_i] = st_q.regs[sel_i] - st_q.regs[src];
                            OP_LD:    st_d.regs[sel_i] = st_q.mem[st_q.ix];
                            OP_ST:    st_d.mem[st_q.ix] = st_q.regs[sel_i];
                            OP_IXADD: st_d.ix = st_q.ix + imm_i[AW-1:0];
                            default:  ;
                        endcase
                    end
                end
            endcase
        end else if (host_we_i) begin
            st_d.mem[host_addr_i] = host_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.active <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/simt_array.sv
module simt_array
    import simt_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int DATA_W     = 8,
    parameter int MEM_DEPTH  = 16,
    parameter int NREGS      = 16,
    parameter int IMEM_DEPTH = 64,
    localparam int LANE_W    = $clog2(LANES),
    localparam int AW        = $clog2(MEM_DEPTH),
    localparam int PC_W      = $clog2(IMEM_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               prog_we,
    input  logic [PC_W-1:0]    prog_addr,
    input  logic [INSTR_W-1:0] prog_data,
    input  logic               host_en,
    input  logic               host_we,
    input  logic [LANE_W-1:0]  host_lane,
    input  logic [AW-1:0]      host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               halted,
    output logic [PC_W-1:0]    pc,
    output logic [LANES-1:0]   active
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } host_t;

    host_t hst_d, hst_q;

    logic              exec;
    op_e               cur_op;
    logic [SEL_W-1:0]  cur_sel;
    logic [IMM_W-1:0]  cur_imm;
    logic              host_ok;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] lane_rd [LANES];

    simt_ctrl #(
        .IMEM_DEPTH (IMEM_DEPTH)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .prog_we_i   (prog_we),
        .prog_addr_i (prog_addr),
        .prog_data_i (prog_data),
        .pc_o        (pc),
        .halted_o    (halted),
        .exec_o      (exec),
        .op_o        (cur_op),
        .sel_o       (cur_sel),
        .imm_o       (cur_imm)
    );

    assign host_ok = host_en & halted;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = host_ok & host_we & (host_lane == LANE_W'(g));

        simt_lane #(
            .DATA_W    (DATA_W),
            .MEM_DEPTH (MEM_DEPTH),
            .NREGS     (NREGS)
        ) lane_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .exec_i       (exec),
            .op_i         (cur_op),
            .sel_i        (cur_sel),
            .imm_i        (cur_imm),
            .host_we_i    (lane_we[g]),
            .host_addr_i  (host_addr),
            .host_wdata_i (host_wdata),
            .active_o     (active[g]),
            .host_rdata_o (lane_rd[g])
        );
    end

    always_comb begin
        hst_d = hst_q;
        if (host_ok && !host_we) begin
            hst_d.rdata = lane_rd[host_lane];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_q <= '0;
        end else begin
            hst_q <= hst_d;
        end
    end

    assign host_rdata = hst_q.rdata;

endmodule

// File: rtl/simt_array_chk.sv
module simt_array_chk #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    parameter int PC_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              halted,
    input logic [PC_W-1:0]   pc,
    input logic [LANES-1:0]  active,
    input logic [DATA_W-1:0] host_rdata,
    input logic [3:0]        op,
    input logic [7:0]        imm
);

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && halted && active == '1)); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op != 4'd0 && op != 4'd9) |=> pc == PC_W'($past(pc) + 1'b1)); // R2

    AST_JMP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op == 4'd9) |=> pc == $past(imm[PC_W-1:0])); // R8

    AST_HALT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && op == 4'd0) |=> (halted && $stable(pc))); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(pc))); // R8

    AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(!halted && (op == 4'd7 || op == 4'd8)) |=> $stable(active)); // R7

    AST_HOST_QUIET_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !halted |=> $stable(host_rdata)); // R9

endmodule

bind simt_array simt_array_chk #(
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .PC_W   (PC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .halted     (halted),
    .pc         (pc),
    .active     (active),
    .host_rdata (host_rdata),
    .op         (cur_op),
    .imm        (cur_imm)
);

// File: tb/simt_array_tb_top.sv
`timescale 1ns/1ps
module simt_array_tb_top;

    localparam logic [3:0] HLT = 4'd0, LDI = 4'd1, ADD = 4'd2, SUB = 4'd3,
                           LD = 4'd4, ST = 4'd5, IXA = 4'd6, SETA = 4'd7,
                           ALLA = 4'd8, JMP = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        prog_we = 1'b0;
    logic [5:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_lane = '0;
    logic [3:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        halted;
    logic [5:0]  pc;
    logic [3:0]  active;

    int checks = 0;
    int errors = 0;
    logic [15:0] prog [$];

    always #2.5 clk = ~clk;

    simt_array dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .prog_we(prog_we),
        .prog_addr(prog_addr), .prog_data(prog_data), .host_en(host_en),
        .host_we(host_we), .host_lane(host_lane), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .halted(halted),
        .pc(pc), .active(active)
    );

    function automatic logic [15:0] ins(logic [3:0] op, logic [3:0] sel, logic [7:0] imm);
        return {op, sel, imm};
    endfunction

    function automatic logic [7:0] pat(int p, int a);
        return 8'(p * 37 + a * 11 + 5);
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic hwr(int p, int a, logic [7:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_lane = 2'(p);
        host_addr = 4'(a); host_wdata = v;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic hrd(int p, int a, output logic [7:0] v);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_lane = 2'(p); host_addr = 4'(a);
        @(negedge clk);
        v = host_rdata;
        host_en = 1'b0;
    endtask

    task automatic mem_is(string tag, int p, int a, int exp);
        logic [7:0] v;
        hrd(p, a, v);
        chk($sformatf("%s lane%0d addr%0d", tag, p, a), v, exp);
    endtask

    task automatic preload();
        for (int p = 0; p < 4; p++)
            for (int a = 0; a < 16; a++)
                hwr(p, a, pat(p, a));
    endtask

    task automatic load();
        foreach (prog[i]) begin
            @(negedge clk);
            prog_we = 1'b1; prog_addr = 6'(i); prog_data = prog[i];
        end
        @(negedge clk);
        prog_we = 1'b0;
    endtask

    task automatic run(output int cyc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!halted) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cyc;
        logic [7:0] v;
        logic [7:0] kv [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};

        // R1: reset state, then zero registers and index observed through a store
        do_reset();
        @(negedge clk);
        chk("R1 pc", pc, 0);
        chk("R1 halted", halted, 1);
        chk("R1 active", active, 4'hF);
        for (int p = 0; p < 4; p++) hwr(p, 0, 8'hA5);
        prog = '{ins(ST, 4'd3, 8'd0), ins(ST, 4'd15, 8'd0), ins(HLT, 0, 0)};
        load();
        run(cyc);
        for (int p = 0; p < 4; p++) mem_is("R1 zero reg", p, 0, 0);

        // R2 R3 R4 R10: arithmetic sweep over immediates
        foreach (kv[k]) begin
            logic [7:0] kk;
            kk = kv[k];
            do_reset();
            preload();
            prog = '{ins(LD, 4'd0, 0), ins(LDI, 4'd1, kk), ins(ADD, 4'd0, 8'd1),
                     ins(IXA, 0, 8'd1), ins(ST, 4'd0, 0), ins(LDI, 4'd2, kk ^ 8'h5A),
                     ins(SUB, 4'd2, 8'd0), ins(IXA, 0, 8'd1), ins(ST, 4'd2, 0),
                     ins(HLT, 0, 0)};
            load();
            run(cyc);
            chk("R2 cycles", cyc, 10);
            chk("R8 halt pc", pc, 9);
            for (int p = 0; p < 4; p++) begin
                logic [7:0] s;
                s = pat(p, 0) + kk;
                mem_is("R3 add", p, 1, s);
                mem_is("R3 sub", p, 2, 8'((kk ^ 8'h5A) - s));
                for (int a = 0; a < 16; a++)
                    if (a != 1 && a != 2) mem_is("R10 untouched", p, a, pat(p, a));
            end
        end

        // R6 R7 R4 R10: predicate masking and per-lane index values
        do_reset();
        preload();
        for (int p = 0; p < 4; p++) hwr(p, 0, 8'(p));
        prog = '{ins(LD, 4'd0, 0), ins(SETA, 4'd0, 0), ins(IXA, 0, 8'd3),
                 ins(LDI, 4'd1, 8'h55), ins(SETA, 4'd2, 0), ins(ST, 4'd1, 0),
                 ins(LDI, 4'd0, 8'd1), ins(SETA, 4'd0, 0), ins(LDI, 4'd1, 8'h99),
                 ins(ST, 4'd1, 0), ins(HLT, 0, 0)};
        load();
        run(cyc);
        chk("R7 all disabled", active, 4'h0);
        mem_is("R4 lane0 own index", 0, 3, 8'h55);
        mem_is("R6 lane0 addr0", 0, 0, 0);
        for (int p = 1; p < 4; p++) begin
            mem_is("R6 skipped lane index", p, 0, 0);
            mem_is("R10 other lane addr3", p, 3, pat(p, 3));
        end
        prog = '{ins(ALLA, 0, 0), ins(IXA, 0, 8'd1), ins(ST, 4'd1, 0), ins(HLT, 0, 0)};
        load();
        run(cyc);
        chk("R7 all enabled", active, 4'hF);
        mem_is("R7 lane0 woke", 0, 4, 8'h55);
        for (int p = 1; p < 4; p++) mem_is("R6 r1 kept zero", p, 1, 0);

        // R8: uniform jump skips an instruction
        do_reset();
        prog = '{ins(LDI, 4'd0, 8'd7), ins(JMP, 0, 8'd3), ins(LDI, 4'd0, 8'd9),
                 ins(ST, 4'd0, 0), ins(HLT, 0, 0)};
        load();
        run(cyc);
        chk("R8 jump cycles", cyc, 4);
        chk("R8 jump halt pc", pc, 4);
        for (int p = 0; p < 4; p++) mem_is("R8 jump skip", p, 0, 7);

        // R5: index wraps modulo 16
        do_reset();
        preload();
        prog = '{ins(LDI, 4'd0, 8'h3C), ins(IXA, 0, 8'hFF), ins(ST, 4'd0, 0),
                 ins(IXA, 0, 8'd2), ins(ST, 4'd0, 0), ins(HLT, 0, 0)};
        load();
        run(cyc);
        for (int p = 0; p < 4; p++) begin
            mem_is("R5 ix 15", p, 15, 8'h3C);
            mem_is("R5 ix wrap 1", p, 1, 8'h3C);
            mem_is("R5 addr0 kept", p, 0, pat(p, 0));
        end

        // R9: host port ignored while running
        do_reset();
        preload();
        prog = '{};
        for (int i = 0; i < 20; i++) prog.push_back(ins(IXA, 0, 8'd0));
        prog.push_back(ins(HLT, 0, 0));
        load();
        hrd(2, 7, v);
        chk("R9 read", v, pat(2, 7));
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (2) @(negedge clk);
        hwr(1, 5, ~pat(1, 5));
        hrd(0, 0, v);
        while (!halted) @(negedge clk);
        chk("R9 rdata held", host_rdata, pat(2, 7));
        mem_is("R9 write ignored", 1, 5, pat(1, 5));
        hwr(3, 9, 8'hC3);
        mem_is("R9 write halted", 3, 9, 8'hC3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule